// File: doc/BRIEF.md
# Four-Lane Column Rate-Match FIFO

This block absorbs the small frequency offset between the recovered receive clock of a four-lane 8b/10b link and the local read clock. Every write-clock cycle one column enters: one decoded byte and one control flag per lane. Every read-clock cycle, once the FIFO has filled to its starting level, one column leaves. Compensation works on whole columns, and only on skip columns, in which every lane holds the K28.0 control character.

A skip column is dropped on the write side when the FIFO is nearly full. A skip column is repeated on the read side when the FIFO is nearly empty, and each repeat is flagged. Any other column is carried through untouched. If the FIFO still overflows or runs dry, the block does not compensate. It raises a status flag, stops, and keeps that flag high until the receiver digital reset clears everything.

The pointers cross between the two clock domains as gray code through two-flop synchronizers. Each side therefore sees an occupancy that is a few cycles old and errs on the safe side.

Top module: `rm_col_fifo`

## Requirements
- R1: A column is a skip column only when all four control flags are 1 and all four bytes equal 0x1C. Lane i is byte in_data[8i+7:8i] with flag in_ctrl[i]. A column that differs in any single lane, or in any single flag, is never inserted or deleted.
- R2: Non-skip columns leave the FIFO unchanged and in arrival order. None is dropped or duplicated while no error flag is set.
- R3: The write side discards an incoming skip column when its occupancy view exceeds DEPTH-4 (default 12). It discards nothing else.
- R4: When the head column is a skip column and the read occupancy view is below 4, the read side emits a copy of it without consuming it. Several copies may follow one another. out_ins is 1 exactly in the cycle of each copy, and only on a skip column.
- R5: After reset, out_valid stays 0 until at least DEPTH/2 (default 8) columns have been written.
- R6: A write that meets a full FIFO sets full_flag instead of compensating. full_flag stays 1, and writing stops, until reset.
- R7: When the running read side finds the FIFO empty, empty_flag is set and out_valid drops to 0. Both stay that way until reset.
- R8: While dig_rst is 1, the FIFO is cleared and out_valid, out_ins, full_flag and empty_flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Recovered write clock |
| rd_clk | input | 1 | Local read clock |
| dig_rst | input | 1 | Receiver digital reset, active high, held for several cycles of both clocks |
| in_data | input | 32 | Incoming column bytes, lane i in bits 8i+7:8i |
| in_ctrl | input | 4 | Incoming control flags, one per lane |
| out_data | output | 32 | Outgoing column bytes |
| out_ctrl | output | 4 | Outgoing control flags |
| out_valid | output | 1 | Outgoing column is meaningful |
| out_ins | output | 1 | Outgoing column is an inserted skip copy |
| full_flag | output | 1 | Overflow status, write domain, sticky until reset |
| empty_flag | output | 1 | Underrun status, read domain, sticky until reset |

## Verification
A corrupt pointer or a faulty gray crossing shows at the output within a few read cycles. Columns come out reordered, repeated or altered, and the in-order comparison against the stream that was sent catches this on the first bad column. A wrong threshold or a wrong skip match has other symptoms. An offset clock that should cause compensation produces no deletions or no insertions, a near-skip column goes missing, or a status flag rises during a run that should have stayed balanced. Flag stickiness and the priming level are both checked at the ports within a handful of cycles of the event.

// File: rtl/rm_pkg.sv
package rm_pkg;
  localparam logic [7:0] SKIP_BYTE = 8'h1C;

  typedef enum logic [1:0] {
    RD_PRIME = 2'd0,
    RD_RUN   = 2'd1,
    RD_DEAD  = 2'd2
  } rd_state_e;
endpackage

// File: rtl/rm_skip_det.sv
module rm_skip_det
  import rm_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [LANES*8-1:0] col_data,
  input  logic [LANES-1:0]   col_ctrl,
  output logic               is_skip
);
  logic [LANES-1:0] hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign hit[i] = col_ctrl[i] && (col_data[8*i +: 8] == SKIP_BYTE);
  end

  assign is_skip = &hit;
endmodule

// File: rtl/rm_gray_sync.sv
module rm_gray_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] s1, s2;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= gray_in;
      s2 <= s1;
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bin_out[i] = ^(s2 >> i);
  end
endmodule

// File: rtl/rm_dpram.sv
module rm_dpram #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int NWORDS = 1 << AW;

  logic [DW-1:0] mem [NWORDS];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rm_col_fifo.sv
module rm_col_fifo
  import rm_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int DEPTH     = 16,
  parameter int LO_MARK   = 4,
  parameter int HI_GAP    = 4,
  parameter int START_LVL = DEPTH / 2
) (
  input  logic               wr_clk,
  input  logic               rd_clk,
  input  logic               dig_rst,
  input  logic [LANES*8-1:0] in_data,
  input  logic [LANES-1:0]   in_ctrl,
  output logic [LANES*8-1:0] out_data,
  output logic [LANES-1:0]   out_ctrl,
  output logic               out_valid,
  output logic               out_ins,
  output logic               full_flag,
  output logic               empty_flag
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam int BW = LANES * 8;
  localparam int DW = LANES * 9;
  localparam logic [PW-1:0] FULL_V  = PW'(DEPTH);
  localparam logic [PW-1:0] HI_V    = PW'(DEPTH - HI_GAP);
  localparam logic [PW-1:0] LO_V    = PW'(LO_MARK);
  localparam logic [PW-1:0] START_V = PW'(START_LVL);

  // ---------------- write domain ----------------
  logic [PW-1:0] wptr, wgray_q, rptr_w, occ_w;
  logic          in_skip, drop_skip, at_full, we;

  rm_skip_det #(.LANES(LANES)) u_wdet (
    .col_data(in_data), .col_ctrl(in_ctrl), .is_skip(in_skip)
  );

  rm_gray_sync #(.W(PW)) u_rsync (
    .clk(wr_clk), .rst(dig_rst), .gray_in(rgray_q), .bin_out(rptr_w)
  );

  assign occ_w     = wptr - rptr_w;
  assign drop_skip = in_skip && (occ_w > HI_V);
  assign at_full   = (occ_w == FULL_V);
  assign we        = !dig_rst && !full_flag && !drop_skip && !at_full;

  always_ff @(posedge wr_clk) begin
    if (dig_rst) begin
      wptr      <= '0;
      wgray_q   <= '0;
      full_flag <= 1'b0;
    end else begin
      wgray_q <= wptr ^ (wptr >> 1);
      if (!full_flag && !drop_skip) begin
        if (at_full) full_flag <= 1'b1;
        else         wptr      <= wptr + 1'b1;
      end
    end
  end

  rm_dpram #(.DW(DW), .AW(AW)) u_mem (
    .wclk(wr_clk), .we(we), .waddr(wptr[AW-1:0]),
    .wdata({in_ctrl, in_data}), .raddr(rptr[AW-1:0]), .rdata(head)
  );

  // ---------------- read domain ----------------
  logic [PW-1:0] rptr, rgray_q, wptr_r, occ_r;
  logic [DW-1:0] head;
  logic          head_skip;
  rd_state_e     rstate;

  rm_gray_sync #(.W(PW)) u_wsync (
    .clk(rd_clk), .rst(dig_rst), .gray_in(wgray_q), .bin_out(wptr_r)
  );

  rm_skip_det #(.LANES(LANES)) u_rdet (
    .col_data(head[BW-1:0]), .col_ctrl(head[DW-1:BW]), .is_skip(head_skip)
  );

  assign occ_r = wptr_r - rptr;

  always_ff @(posedge rd_clk) begin
    if (dig_rst) begin
      rptr       <= '0;
      rgray_q    <= '0;
      rstate     <= RD_PRIME;
      out_data   <= '0;
      out_ctrl   <= '0;
      out_valid  <= 1'b0;
      out_ins    <= 1'b0;
      empty_flag <= 1'b0;
    end else begin
      rgray_q <= rptr ^ (rptr >> 1);
      case (rstate)
        RD_PRIME: begin
          out_valid <= 1'b0;
          out_ins   <= 1'b0;
          if (occ_r >= START_V) rstate <= RD_RUN;
        end
        RD_RUN: begin
          if (occ_r == '0) begin
            empty_flag <= 1'b1;
            out_valid  <= 1'b0;
            out_ins    <= 1'b0;
            rstate     <= RD_DEAD;
          end else begin
            out_data  <= head[BW-1:0];
            out_ctrl  <= head[DW-1:BW];
            out_valid <= 1'b1;
            if (head_skip && (occ_r < LO_V)) begin
              out_ins <= 1'b1;
            end else begin
              out_ins <= 1'b0;
              rptr    <= rptr + 1'b1;
            end
          end
        end
        default: begin
          out_valid <= 1'b0;
          out_ins   <= 1'b0;
        end
      endcase
    end
  end

  // ---------------- assertions ----------------
  p_full_sticky_r6: assert property (@(posedge wr_clk) disable iff (dig_rst)
    full_flag |=> full_flag)
    else $error("full_flag released without reset");

  p_no_overflow_r6: assert property (@(posedge wr_clk) disable iff (dig_rst)
    occ_w <= FULL_V)
    else $error("write-side occupancy beyond depth");

  p_empty_sticky_r7: assert property (@(posedge rd_clk) disable iff (dig_rst)
    empty_flag |=> (empty_flag && !out_valid))
    else $error("empty_flag released or output resumed without reset");

  p_ins_is_skip_r4: assert property (@(posedge rd_clk) disable iff (dig_rst)
    out_ins |-> (out_valid && (out_ctrl == '1) && (out_data == {LANES{SKIP_BYTE}})))
    else $error("inserted column is not a skip column");

  p_no_underflow_r7: assert property (@(posedge rd_clk) disable iff (dig_rst)
    occ_r <= FULL_V)
    else $error("read-side occupancy beyond depth");
endmodule

// File: tb/sim_rm_col_fifo.sv
`timescale 1ns/10ps
module sim_rm_col_fifo;
  logic        wr_clk = 1'b0, rd_clk = 1'b0, dig_rst = 1'b1;
  logic [31:0] in_data = '0, out_data;
  logic [3:0]  in_ctrl = '0, out_ctrl;
  logic        out_valid, out_ins, full_flag, empty_flag;

  real wr_half = 9.9;
  bit  skip_en = 1'b1;
  bit  chk_en  = 1'b0;
  bit  seen_valid = 1'b0;
  int  n_chk = 0, n_fail = 0;
  int  push_cnt = 0, ins_cnt = 0, del_cnt = 0, matched = 0, wd = 0;
  int  gen_n = 0;
  logic [35:0] q[$];

  rm_col_fifo u0 (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .dig_rst(dig_rst),
    .in_data(in_data), .in_ctrl(in_ctrl),
    .out_data(out_data), .out_ctrl(out_ctrl), .out_valid(out_valid),
    .out_ins(out_ins), .full_flag(full_flag), .empty_flag(empty_flag)
  );

  initial forever #10 rd_clk = ~rd_clk;
  initial begin
    #0.25;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  function automatic bit skipc(logic [35:0] c);
    return c == {4'hF, 32'h1C1C1C1C};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // stimulus: data columns, all-K28.5 columns, near-skip columns, skip columns
  initial forever begin
    @(negedge wr_clk);
    gen_n++;
    case (gen_n % 8)
      0: if (skip_en) begin in_data = 32'h1C1C1C1C; in_ctrl = 4'hF; end
         else begin in_data = {4{gen_n[7:0]}}; in_ctrl = 4'h0; end
      2: begin in_data = 32'hBCBCBCBC; in_ctrl = 4'hF; end
      4: case ((gen_n / 8) % 3)
           0: begin in_data = 32'h1C1C1C1C; in_ctrl = 4'h7; end
           1: begin in_data = 32'h1C1C1CBC; in_ctrl = 4'hF; end
           default: begin in_data = 32'h1C7C1C1C; in_ctrl = 4'hF; end
         endcase
      default: begin
        in_data = {gen_n[7:0] + 8'd3, gen_n[7:0] + 8'd2, gen_n[7:0] + 8'd1, gen_n[7:0]};
        in_ctrl = 4'h0;
      end
    endcase
  end

  // every column the design sees outside reset goes into the reference stream
  always @(posedge wr_clk) begin
    if (!dig_rst) begin
      q.push_back({in_ctrl, in_data});
      push_cnt++;
    end
  end

  // reference comparison on every read clock
  always @(negedge rd_clk) begin
    logic [35:0] col, exp;
    col = {out_ctrl, out_data};
    if (chk_en && out_valid) begin
      if (!seen_valid) begin
        seen_valid = 1'b1;
        chk(push_cnt >= 8, "R5", "columns written before first output", push_cnt, 8);
      end
      if (out_ins) begin
        chk(skipc(col), "R4", "inserted column content", col, {4'hF, 32'h1C1C1C1C});
        ins_cnt++;
      end else begin
        while (q.size() > 0 && skipc(q[0]) && !skipc(col)) begin
          void'(q.pop_front());
          del_cnt++;
        end
        if (q.size() == 0) begin
          chk(1'b0, "R2", "output with no column pending", col, 0);
        end else begin
          exp = q.pop_front();
          chk(col == exp, "R1/R2/R3", "passed column", col, exp);
          matched++;
        end
      end
    end
  end

  always @(posedge rd_clk) begin
    wd++;
    if (wd > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below 150000", wd);
      report();
      $finish;
    end
  end

  task automatic do_reset(real half, bit skips);
    chk_en = 1'b0;
    @(negedge wr_clk);
    dig_rst = 1'b1;
    wr_half = half;
    skip_en = skips;
    repeat (12) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(!out_valid && !out_ins, "R8", "outputs in reset", {out_valid, out_ins}, 0);
    chk(!full_flag && !empty_flag, "R8", "flags in reset", {full_flag, empty_flag}, 0);
    q.delete();
    push_cnt = 0; ins_cnt = 0; del_cnt = 0; matched = 0; seen_valid = 1'b0;
    chk_en = 1'b1;
    @(negedge wr_clk);
    dig_rst = 1'b0;
  endtask

  initial begin
    // fast writer with skips: deletions keep it balanced
    do_reset(9.9, 1'b1);
    repeat (3000) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(del_cnt > 0, "R3", "deletions with fast writer", del_cnt, 1);
    chk(!full_flag && !empty_flag, "R3", "no flag with fast writer", {full_flag, empty_flag}, 0);
    chk(matched >= 2800, "R2", "columns delivered", matched, 2800);

    // slow writer with skips: insertions keep it balanced
    do_reset(10.1, 1'b1);
    repeat (3000) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(ins_cnt > 0, "R4", "insertions with slow writer", ins_cnt, 1);
    chk(!full_flag && !empty_flag, "R4", "no flag with slow writer", {full_flag, empty_flag}, 0);
    chk(matched >= 2700, "R2", "columns delivered", matched, 2700);

    // much faster writer, no skips: overflow is only flagged
    do_reset(8.0, 1'b0);
    for (int i = 0; i < 500 && !full_flag; i++) @(posedge rd_clk);
    @(negedge wr_clk);
    chk(full_flag, "R6", "full_flag raised", full_flag, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge wr_clk);
      chk(full_flag, "R6", "full_flag held", full_flag, 1);
    end
    chk(del_cnt == 0 && ins_cnt == 0, "R6", "no compensation at full", del_cnt + ins_cnt, 0);

    // much slower writer, no skips: underrun is only flagged
    do_reset(12.0, 1'b0);
    for (int i = 0; i < 500 && !empty_flag; i++) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(empty_flag, "R7", "empty_flag raised", empty_flag, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge rd_clk);
      chk(empty_flag && !out_valid, "R7", "stopped after underrun", {empty_flag, out_valid}, 2'b10);
    end
    chk(ins_cnt == 0 && !full_flag, "R7", "no insertion without skips", ins_cnt, 0);

    // reset clears the error state
    do_reset(10.0, 1'b1);
    repeat (40) @(posedge rd_clk);
    @(negedge rd_clk);
    chk(out_valid && !empty_flag, "R8", "running again after reset", {out_valid, empty_flag}, 2'b10);

    chk_en = 1'b0;
    report();
    $finish;
  end
endmodule